// File: doc/BRIEF.md
# Link Auto-Negotiation Resolver

This block runs a reduced form of twisted-pair link auto-negotiation. It sends and receives 16-bit capability codewords as bursts of link pulses. Each pulse is a single-cycle strobe on a digital line. Once the block holds a stable codeword from the link partner, it selects the fastest speed and duplex pair that both sides advertise. It then reports that pair together with a done flag.

When negotiation is switched off in the control value, the block sends nothing on the line. It takes speed and duplex straight from two control bits. Pulses are plain strobes with no payload of their own, so neither the pulse lines nor the configuration inputs use a valid/ready handshake. Every pin is a level or a strobe, and no back-pressure exists.

Capability codeword layout:

| Bits | Meaning |
|------|---------|
| 4:0 | selector field |
| 5 | 10 Mb/s half duplex |
| 6 | 10 Mb/s full duplex |
| 7 | 100 Mb/s half duplex |
| 8 | 100 Mb/s full duplex |
| 15:9 | reserved or flag bits, carried on the line but not resolved |

Top module: `link_autoneg`

## Requirements
- R1: After reset, `an_done`, `an_fail`, `link_speed`, `link_duplex` and `tx_pulse` are all 0.
- R2: The control value `ctrl_cfg` has bit 2 as the negotiation enable, bit 1 as the forced speed (1 means 100 Mb/s) and bit 0 as the forced duplex (1 means full duplex). While bit 2 is 0, within two cycles `link_speed` and `link_duplex` follow bits 1 and 0, `an_done` is 1, `an_fail` is 0, and `tx_pulse` stays 0.
- R3: A transmitted burst has 33 pulse slots spaced `SLOT_CYC` cycles apart. Even slots always carry a clock pulse. Slot 2k+1 carries a pulse exactly when bit k of the advertised word is 1, so bit 0 goes first. A new burst starts every `BURST_SLOTS*SLOT_CYC` cycles.
- R4: When bit 2 of `ctrl_cfg` goes to 1, either out of reset or after being 0, the first burst starts at once with a clock pulse. Its data is the current `adv_word`.
- R5: Only codeword bits 8 to 5 take part in resolution: bit 8 = 100 Mb/s full, bit 7 = 100 Mb/s half, bit 6 = 10 Mb/s full, bit 5 = 10 Mb/s half.
- R6: The chosen mode is the first one present in both the local word and the partner word, in this order: 100 full, 100 half, 10 full, 10 half. `link_speed`=1 means 100 Mb/s and `link_duplex`=1 means full duplex.
- R7: A partner codeword is accepted only after three consecutive received codewords that are identical. Fewer repeats, or a different word in between, leave `an_done` and `an_fail` at 0.
- R8: If no pulse arrives within `RX_TIMEOUT` cycles of the last clock pulse during reception, the partial codeword is dropped and reception restarts. A dropped partial word does not break a run of identical words.
- R9: If the accepted partner word shares no mode with the local word, `an_fail` goes to 1 and `an_done` stays 0 until negotiation is disabled.
- R10: Once `an_done` is 1 in negotiated mode, `link_speed` and `link_duplex` stay fixed regardless of further received bursts, until negotiation is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_word | input | 16 | Local capability codeword to advertise |
| ctrl_cfg | input | 3 | Negotiation enable, forced speed, forced duplex |
| rx_pulse | input | 1 | Received link pulse strobe |
| tx_pulse | output | 1 | Transmitted link pulse strobe |
| link_speed | output | 1 | Resolved speed, 1 = 100 Mb/s |
| link_duplex | output | 1 | Resolved duplex, 1 = full duplex |
| an_done | output | 1 | Mode resolved or forced |
| an_fail | output | 1 | Negotiation found no common mode |

## Verification
The hardest situation to reach from the ports is a burst cut off partway through and placed between identical codewords. The receiver must drop the fragment on timeout rather than merge it into the next burst, and the run of repeats must survive. The stimulus sends two full copies of a word, then a burst truncated after a few bits, then a gap longer than the timeout, then one more full copy. Acceptance after that fourth transmission shows the fragment was dropped. A second directed pattern alternates two words, so the run of repeats is interrupted just short of acceptance.

// File: rtl/autoneg_pkg.sv
package autoneg_pkg;
  localparam int CW_BITS  = 16;
  localparam int CW_SLOTS = 2 * CW_BITS + 1;
  localparam int MODE_LSB = 5;
  localparam int MODE_N   = 4;

  typedef enum logic [2:0] {
    AN_IDLE,
    AN_FORCED,
    AN_NEGOT,
    AN_DONE,
    AN_FAIL
  } an_state_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] rank;
  } an_pick_t;

  // common[3]=100 full, [2]=100 half, [1]=10 full, [0]=10 half
  function automatic an_pick_t pick_mode(input logic [MODE_N-1:0] common);
    an_pick_t p;
    p = '0;
    for (int i = 0; i < MODE_N; i++) begin
      if (common[i]) begin
        p.ok   = 1'b1;
        p.rank = 2'(i);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/an_burst_tx.sv
module an_burst_tx
  import autoneg_pkg::*;
#(
  parameter int SLOT_CYC    = 4,
  parameter int BURST_SLOTS = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [CW_BITS-1:0] word_i,
  output logic               pulse_o
);
  localparam int SUB_W  = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int SLOT_W = $clog2(BURST_SLOTS + 1);

  logic [SUB_W-1:0]   sub_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [CW_BITS-1:0] word_q;
  logic               pulse_q;
  logic [3:0]         bit_idx;
  logic               in_burst;
  logic               slot_fire;

  assign bit_idx   = slot_q[4:1];
  assign in_burst  = (slot_q < SLOT_W'(CW_SLOTS));
  assign slot_fire = (sub_q == '0) && in_burst &&
                     (!slot_q[0] || word_q[bit_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      sub_q   <= '0;
      slot_q  <= '0;
      pulse_q <= 1'b0;
      word_q  <= '0;
    end else begin
      pulse_q <= slot_fire;
      if (sub_q == '0 && slot_q == '0) word_q <= word_i;
      if (sub_q == SUB_W'(SLOT_CYC - 1)) begin
        sub_q  <= '0;
        slot_q <= (slot_q == SLOT_W'(BURST_SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign pulse_o = pulse_q;

  // R2: a disabled transmitter emits no pulse on the following cycle
  a_r2_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pulse_o);
  // R3: pulses are at least one slot apart when slots are wider than a cycle
  a_r3_pulse_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && SLOT_CYC > 1) |=> !pulse_o);
endmodule

// File: rtl/an_burst_rx.sv
module an_burst_rx
  import autoneg_pkg::*;
#(
  parameter int SLOT_CYC   = 4,
  parameter int RX_TIMEOUT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               pulse_i,
  output logic               vld_o,
  output logic [CW_BITS-1:0] word_o
);
  localparam int DATA_LIM = SLOT_CYC + SLOT_CYC / 2;
  localparam int CNT_W    = $clog2(RX_TIMEOUT + 1);

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [4:0]         bits_q;
  logic               got1_q;
  logic [CW_BITS-1:0] sh_q;
  logic               vld_q;
  logic               is_data;
  logic               expired;

  assign is_data = (cnt_q < CNT_W'(DATA_LIM));
  assign expired = (cnt_q >= CNT_W'(RX_TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bits_q   <= '0;
      got1_q   <= 1'b0;
      sh_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!active_q) begin
        if (pulse_i) begin
          active_q <= 1'b1;
          cnt_q    <= CNT_W'(1);
          bits_q   <= '0;
          got1_q   <= 1'b0;
        end
      end else if (pulse_i) begin
        if (is_data) begin
          got1_q <= 1'b1;
          cnt_q  <= cnt_q + 1'b1;
        end else begin
          sh_q   <= {got1_q, sh_q[CW_BITS-1:1]};
          got1_q <= 1'b0;
          cnt_q  <= CNT_W'(1);
          bits_q <= bits_q + 1'b1;
          if (bits_q == 5'(CW_BITS - 1)) begin
            vld_q    <= 1'b1;
            active_q <= 1'b0;
          end
        end
      end else if (expired) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vld_o  = vld_q;
  assign word_o = sh_q;

  // R8: a silent window past the timeout drops the word being collected
  a_r8_timeout_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && active_q && !pulse_i && expired) |=> (!active_q && !vld_o));
  // R3: a word is reported only as the receiver goes idle
  a_r3_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> !active_q);
endmodule

// File: rtl/an_match.sv
module an_match
  import autoneg_pkg::*;
#(
  parameter int REPEAT_N = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               vld_i,
  input  logic [CW_BITS-1:0] word_i,
  output logic               acc_o,
  output logic [CW_BITS-1:0] word_o
);
  localparam int RUN_W = $clog2(REPEAT_N + 1);

  logic [CW_BITS-1:0] last_q;
  logic [RUN_W-1:0]   run_q;
  logic               acc_q;
  logic               same;

  assign same = (word_i == last_q) && (run_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      last_q <= '0;
      run_q  <= '0;
      acc_q  <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      if (vld_i) begin
        if (same) begin
          if (run_q != RUN_W'(REPEAT_N)) run_q <= run_q + 1'b1;
          acc_q <= (run_q == RUN_W'(REPEAT_N - 1));
        end else begin
          last_q <= word_i;
          run_q  <= RUN_W'(1);
        end
      end
    end
  end

  assign acc_o  = acc_q;
  assign word_o = last_q;

  // R7: acceptance only directly follows a received word
  a_r7_accept_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> $past(vld_i));
  // R7: acceptance is a single strobe per run
  a_r7_accept_single: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |=> !acc_o);
endmodule

// File: rtl/an_resolve.sv
module an_resolve
  import autoneg_pkg::*;
(
  input  logic [CW_BITS-1:0] local_i,
  input  logic [CW_BITS-1:0] partner_i,
  output logic [MODE_N-1:0]  common_o,
  output logic               ok_o,
  output logic               speed_o,
  output logic               duplex_o
);
  an_pick_t pick;

  always_comb begin
    common_o = local_i[MODE_LSB +: MODE_N] & partner_i[MODE_LSB +: MODE_N];
    pick     = pick_mode(common_o);
    ok_o     = pick.ok;
    speed_o  = pick.rank[1];
    duplex_o = pick.rank[0];
  end

  // R9: a pick exists exactly when some mode is shared
  always_comb begin
    a_r9_ok_iff_common: assert (ok_o == (common_o != '0));
  end
endmodule

// File: rtl/link_autoneg.sv
module link_autoneg
  import autoneg_pkg::*;
#(
  parameter int SLOT_CYC    = 4,
  parameter int BURST_SLOTS = 40,
  parameter int RX_TIMEOUT  = 12,
  parameter int REPEAT_N    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] adv_word,
  input  logic [2:0]  ctrl_cfg,
  input  logic        rx_pulse,
  output logic        tx_pulse,
  output logic        link_speed,
  output logic        link_duplex,
  output logic        an_done,
  output logic        an_fail
);
  an_state_e st_q, nxt;

  logic               en;
  logic               tx_en;
  logic               rx_en;
  logic               rx_vld;
  logic [CW_BITS-1:0] rx_word;
  logic               acc;
  logic [CW_BITS-1:0] lp_word;
  logic [MODE_N-1:0]  common;
  logic               pick_ok;
  logic               pick_spd;
  logic               pick_dup;
  logic [MODE_N-1:0]  common_q;
  logic               spd_q, dup_q, done_q, fail_q;

  assign en    = ctrl_cfg[2];
  assign tx_en = (st_q == AN_NEGOT) || (st_q == AN_DONE) || (st_q == AN_FAIL);
  assign rx_en = (st_q == AN_NEGOT);

  an_burst_tx #(.SLOT_CYC(SLOT_CYC), .BURST_SLOTS(BURST_SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(tx_en), .word_i(adv_word), .pulse_o(tx_pulse)
  );

  an_burst_rx #(.SLOT_CYC(SLOT_CYC), .RX_TIMEOUT(RX_TIMEOUT)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .pulse_i(rx_pulse),
    .vld_o(rx_vld), .word_o(rx_word)
  );

  an_match #(.REPEAT_N(REPEAT_N)) u_match (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .vld_i(rx_vld), .word_i(rx_word),
    .acc_o(acc), .word_o(lp_word)
  );

  an_resolve u_res (
    .local_i(adv_word), .partner_i(lp_word), .common_o(common),
    .ok_o(pick_ok), .speed_o(pick_spd), .duplex_o(pick_dup)
  );

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      AN_IDLE, AN_FORCED: nxt = en ? AN_NEGOT : AN_FORCED;
      AN_NEGOT: begin
        if (!en)      nxt = AN_FORCED;
        else if (acc) nxt = pick_ok ? AN_DONE : AN_FAIL;
      end
      default: nxt = en ? st_q : AN_FORCED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= AN_IDLE;
      spd_q    <= 1'b0;
      dup_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      common_q <= '0;
    end else begin
      st_q <= nxt;
      unique case (nxt)
        AN_FORCED: begin
          spd_q  <= ctrl_cfg[1];
          dup_q  <= ctrl_cfg[0];
          done_q <= 1'b1;
          fail_q <= 1'b0;
        end
        AN_NEGOT: begin
          spd_q  <= 1'b0;
          dup_q  <= 1'b0;
          done_q <= 1'b0;
          fail_q <= 1'b0;
        end
        AN_DONE: begin
          if (st_q == AN_NEGOT) begin
            spd_q    <= pick_spd;
            dup_q    <= pick_dup;
            done_q   <= 1'b1;
            common_q <= common;
          end
        end
        AN_FAIL: begin
          if (st_q == AN_NEGOT) fail_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign link_speed  = spd_q;
  assign link_duplex = dup_q;
  assign an_done     = done_q;
  assign an_fail     = fail_q;

  // R9: done and fail never show together
  a_r9_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(an_done && an_fail));
  // R10: a negotiated result holds while negotiation stays enabled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AN_DONE && en) |=> (an_done && $stable(link_speed) && $stable(link_duplex)));
  // R6: the reported mode is shared and no better mode was shared
  a_r6_best_common: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AN_DONE) |-> ((common_q >> {link_speed, link_duplex}) == 4'b0001));
  // R2: forced mode reports done and stays off the line
  a_r2_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AN_FORCED && $past(st_q == AN_FORCED)) |-> (an_done && !an_fail && !tx_pulse));
endmodule

// File: tb/link_autoneg_tb.sv
module link_autoneg_tb;
  localparam int SLOT  = 4;
  localparam int BSLOT = 40;
  localparam int RXTO  = 12;
  localparam int GAP   = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adv_word = '0;
  logic [2:0]  ctrl_cfg = '0;
  logic        rx_pulse = 1'b0;
  logic        tx_pulse, link_speed, link_duplex, an_done, an_fail;

  int total = 0;
  int bad = 0;
  int tx_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  link_autoneg #(.SLOT_CYC(SLOT), .BURST_SLOTS(BSLOT), .RX_TIMEOUT(RXTO), .REPEAT_N(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .adv_word(adv_word), .ctrl_cfg(ctrl_cfg),
    .rx_pulse(rx_pulse), .tx_pulse(tx_pulse), .link_speed(link_speed),
    .link_duplex(link_duplex), .an_done(an_done), .an_fail(an_fail)
  );

  always @(negedge clk) if (tx_pulse) tx_seen++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {ok, speed, duplex}
  function automatic logic [2:0] exp_mode(input logic [15:0] a, input logic [15:0] p);
    logic [3:0] c;
    c = a[8:5] & p[8:5];
    if (c[3]) return 3'b111;
    if (c[2]) return 3'b110;
    if (c[1]) return 3'b101;
    if (c[0]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic slot(input logic b);
    @(negedge clk) rx_pulse = b;
    @(negedge clk) rx_pulse = 1'b0;
    repeat (SLOT - 2) @(negedge clk);
  endtask

  task automatic send_burst(input logic [15:0] w, input int nbits);
    slot(1'b1);
    for (int i = 0; i < nbits; i++) begin
      slot(w[i]);
      slot(1'b1);
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic restart(input logic [15:0] a);
    @(negedge clk);
    ctrl_cfg = 3'b000;
    adv_word = a;
    repeat (4) @(negedge clk);
    ctrl_cfg = 3'b100;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_result(input string req, input logic [15:0] a, input logic [15:0] p);
    logic [2:0] e;
    e = exp_mode(a, p);
    repeat (6) @(negedge clk);
    check(req, int'(an_done), int'(e[2]));
    check(req, int'(an_fail), int'(!e[2]));
    if (e[2]) check(req, int'({link_speed, link_duplex}), int'(e[1:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, p, q, w;
    logic [2:0]  e0;
    int          n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R1
    check("R1 done", int'(an_done), 0);
    check("R1 fail", int'(an_fail), 0);
    check("R1 tx", int'(tx_pulse), 0);
    check("R1 mode", int'({link_speed, link_duplex}), 0);
    rst_n = 1'b1;

    // R2: forced modes, no pulses
    for (int f = 0; f < 4; f++) begin
      @(negedge clk) ctrl_cfg = {1'b0, 2'(f)};
      repeat (3) @(negedge clk);
      n = tx_seen;
      repeat (200) @(negedge clk);
      check("R2 forced mode", int'({link_speed, link_duplex}), f);
      check("R2 forced done", int'({an_done, an_fail}), 2);
      check("R2 no bursts", tx_seen - n, 0);
    end

    // R3 R4: transmitted burst content and repetition
    for (int k = 0; k < 3; k++) begin
      w = 16'($urandom);
      @(negedge clk) adv_word = w;
      ctrl_cfg = 3'b100;
      n = 0;
      while (!tx_pulse && n < 20) begin @(negedge clk); n++; end
      check("R4 burst starts on enable", n <= 3 ? 1 : 0, 1);
      a = '0;
      for (int i = 0; i < 16; i++) begin
        repeat (SLOT) @(negedge clk);
        a[i] = tx_pulse;
        repeat (SLOT) @(negedge clk);
        if (!tx_pulse) a[i] = ~w[i];
      end
      check("R3 burst data", int'(a), int'(w));
      n = 32 * SLOT;
      do begin @(negedge clk); n++; end while (!tx_pulse && n < 1000);
      check("R3 burst period", n, BSLOT * SLOT);
      @(negedge clk) ctrl_cfg = 3'b000;
      repeat (4) @(negedge clk);
    end

    // R6 R5: each priority level directed
    for (int m = 0; m < 4; m++) begin
      a = 16'h0001 | (16'h1E0 & (16'hFFFF >> (3 - m) * 0)) ;
      a = 16'h01E1;
      p = 16'h0001 | (16'h0020 << m);
      restart(a);
      repeat (3) send_burst(p, 16);
      check_result("R6 priority", a, p);
    end
    // R5: reserved bits do not resolve
    a = 16'hFE01 | 16'h0040; p = 16'hFE01 | 16'h0020;
    restart(a);
    repeat (3) send_burst(p, 16);
    check_result("R5 reserved bits ignored", a, p);

    // R9: no common mode
    a = 16'h0181; p = 16'h0061;
    restart(a);
    repeat (3) send_burst(p, 16);
    check_result("R9 no common", a, p);
    check("R9 fail holds", int'(an_done), 0);

    // R7: interrupted runs
    a = 16'h01E1; p = 16'h0101; q = 16'h0041;
    restart(a);
    send_burst(p, 16); send_burst(p, 16); send_burst(q, 16); send_burst(q, 16);
    repeat (6) @(negedge clk);
    check("R7 two repeats not enough", int'({an_done, an_fail}), 0);
    send_burst(q, 16);
    check_result("R7 third repeat accepts", a, q);

    // R8: truncated burst between identical words
    restart(a);
    send_burst(p, 16); send_burst(p, 16);
    send_burst(q, 5);
    repeat (6) @(negedge clk);
    check("R8 partial not accepted", int'({an_done, an_fail}), 0);
    send_burst(p, 16);
    check_result("R8 partial dropped", a, p);

    // R10: result held after done
    e0 = exp_mode(a, p);
    repeat (3) send_burst(q, 16);
    repeat (6) @(negedge clk);
    check("R10 held mode", int'({link_speed, link_duplex}), int'(e0[1:0]));
    check("R10 held done", int'(an_done), 1);

    // random negotiations
    for (int r = 0; r < 16; r++) begin
      a = {7'($urandom), 4'($urandom), 5'h01};
      p = {7'($urandom), 4'($urandom), 5'h01};
      restart(a);
      repeat (3) send_burst(p, 16);
      check_result("R6 random", a, p);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule